// File: doc/BRIEF.md
# Wormhole Flit Forwarding Port

This block is the forwarding stage of one router input in a wormhole-switched network of compute nodes. Fixed-length flits arrive on a valid/ready input channel and enter a small flit buffer of a few entries. The flit at the front of the buffer is steered to one of two outputs: a local-eject channel that hands packets to this node, or a pass-through channel that carries them on to the next router. The choice is made once per packet. A compare of the head flit's destination field against the node's own identifier decides it.

When a multi-flit packet's head leaves, the chosen output is locked to that packet. Every following flit goes to the same output in arrival order until the tail flit has left. Flits of two packets therefore never mix on an output. Forwarding starts one cycle after the head is buffered, without waiting for the rest of the packet. A neighbouring stage can claim an output through a hold input. A head flit aimed at a claimed output waits until the claim is released. The lock this port holds is shown to neighbours on a matching output.

Top module: `wh_fwd_port`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `out_valid` is 00, `lock_own` is 00 and `in_ready` is 1.
- R2: A flit whose kind field `flit[9:8]` is 01 (head) or 11 (single-flit packet) is routed by its destination field `flit[3:0]`. If the field equals `NODE_ID` it goes to channel 0 (eject), otherwise to channel 1 (pass). The flit appears on `out_flit` unchanged.
- R3: After a head flit (01) leaves on a channel, each later flit, up to and including the tail flit (kind 10), leaves on that same channel whatever its data bits hold. Body flits have kind 00. The channel's `lock_own` bit is 1 from the cycle after the head transfer through the cycle of the tail transfer, and 0 in the cycle after that. While that bit is 1, the other channel's `out_valid` stays 0.
- R4: Flits leave in the order they were accepted, each exactly once.
- R5: While the addressed channel's `out_ready` is 0, the offered flit stays on `out_flit` with `out_valid` held. Once `DEPTH` flits are buffered, `in_ready` is 0.
- R6: A head flit that reaches the front of the buffer while no packet is locked is not offered while `ext_hold` for its channel is 1. It is offered in the same cycle that the hold bit falls.
- R7: A single-flit packet (kind 11) is forwarded without either `lock_own` bit rising.
- R8: A flit accepted into an empty buffer is offered on its output in the next cycle, before the later flits of its packet have been sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Buffer can take a flit |
| in_flit | input | 10 | Input flit: kind in [9:8], data in [7:0], destination in [3:0] of a head |
| ext_hold | input | 2 | Per channel: output claimed by a neighbouring stage |
| out_valid | output | 2 | Per channel: flit offered (bit 0 eject, bit 1 pass) |
| out_ready | input | 2 | Per channel: downstream can take a flit |
| out_flit | output | 10 | Offered flit, shared by both channels |
| lock_own | output | 2 | Per channel: output locked by a packet of this port |

## Verification
The assertions assume well-framed input. An idle port only ever sees a head or single-flit packet at the buffer front, a locked port never sees a new head there, and no packet is longer than the 512-bit bound allows. They also assume a neighbour raises `ext_hold` only on a channel this port does not hold. The stimulus builds every packet as a head, then bodies, then a tail, or as a lone single-flit packet of at most five flits. It raises a hold bit only on a channel that the bench's own lock model shows as free.

// File: rtl/wh_pkg.sv
package wh_pkg;

    localparam int FLIT_DATA_W = 8;
    localparam int DEST_W      = 4;
    localparam int NUM_CH      = 2;

    // bit 0 marks the start of a packet, bit 1 its end
    typedef enum logic [1:0] {
        K_BODY = 2'b00,
        K_HEAD = 2'b01,
        K_TAIL = 2'b10,
        K_SOLO = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e                  kind;
        logic [FLIT_DATA_W-1:0] data;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

    typedef enum logic {
        CH_EJECT = 1'b0,
        CH_PASS  = 1'b1
    } chan_e;

    function automatic logic opens_pkt(kind_e k);
        return k[0];
    endfunction

    function automatic logic closes_pkt(kind_e k);
        return k[1];
    endfunction

    function automatic logic [DEST_W-1:0] dest_of(flit_t f);
        return f.data[DEST_W-1:0];
    endfunction

    function automatic chan_e pick_chan(flit_t f, logic [DEST_W-1:0] id);
        return (dest_of(f) == id) ? CH_EJECT : CH_PASS;
    endfunction

endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo
    import wh_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  flit_t wr_flit,
    input  logic  rd_en,
    output flit_t rd_flit,
    output logic  full,
    output logic  empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    flit_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_flit;
    end

    assign rd_flit = mem[rd_ptr];
    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full |-> !wr_en); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        empty |-> !rd_en); // R4

endmodule

// File: rtl/wh_route_lock.sv
module wh_route_lock
    import wh_pkg::*;
#(
    parameter int NODE_ID   = 5,
    parameter int MAX_FLITS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              front_vld,
    input  flit_t             front,
    input  logic [NUM_CH-1:0] ext_hold,
    input  logic [NUM_CH-1:0] out_ready,
    output chan_e             sel,
    output logic              go,
    output logic              fire,
    output logic [NUM_CH-1:0] lock_own
);

    localparam int CNT_W = $clog2(MAX_FLITS + 1);

    logic             locked;
    chan_e            cur_sel;
    chan_e            cand;
    logic [CNT_W-1:0] flit_cnt;

    always_comb begin
        cand = pick_chan(front, DEST_W'(NODE_ID));
        sel  = locked ? cur_sel : cand;
        go   = front_vld && (locked || (opens_pkt(front.kind) && !ext_hold[cand]));
        fire = go && out_ready[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            cur_sel  <= CH_EJECT;
            flit_cnt <= '0;
        end else if (fire) begin
            if (closes_pkt(front.kind)) begin
                locked   <= 1'b0;
                flit_cnt <= '0;
            end else begin
                flit_cnt <= flit_cnt + 1'b1;
                if (opens_pkt(front.kind)) begin
                    locked  <= 1'b1;
                    cur_sel <= cand;
                end
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lock
        assign lock_own[c] = locked && (cur_sel == chan_e'(c));
    end

    // input framing assumptions
    AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (rst)
        front_vld && (lock_own == '0) |-> opens_pkt(front.kind)); // R3

    AST_FRAME_BODY: assert property (@(posedge clk) disable iff (rst)
        front_vld && (lock_own != '0) |-> !opens_pkt(front.kind)); // R3

    AST_PKT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fire |-> (flit_cnt < CNT_W'(MAX_FLITS))); // R4

    AST_SOLO_NOLOCK: assert property (@(posedge clk) disable iff (rst)
        fire && (front.kind == K_SOLO) |=> (lock_own == '0)); // R7

endmodule

// File: rtl/wh_fwd_port.sv
module wh_fwd_port
    import wh_pkg::*;
#(
    parameter int DEPTH        = 4,
    parameter int NODE_ID      = 5,
    parameter int PKT_MAX_BITS = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic [NUM_CH-1:0] ext_hold,
    output logic [NUM_CH-1:0] out_valid,
    input  logic [NUM_CH-1:0] out_ready,
    output logic [FLIT_W-1:0] out_flit,
    output logic [NUM_CH-1:0] lock_own
);

    localparam int MAX_FLITS = PKT_MAX_BITS / FLIT_DATA_W;

    flit_t wr_flit;
    flit_t front;
    logic  full;
    logic  empty;
    logic  go;
    logic  fire;
    chan_e sel;

    assign wr_flit  = flit_t'(in_flit);
    assign in_ready = !full;

    wh_flit_fifo #(
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (in_valid && !full),
        .wr_flit(wr_flit),
        .rd_en  (fire),
        .rd_flit(front),
        .full   (full),
        .empty  (empty)
    );

    wh_route_lock #(
        .NODE_ID  (NODE_ID),
        .MAX_FLITS(MAX_FLITS)
    ) u_route (
        .clk      (clk),
        .rst      (rst),
        .front_vld(!empty),
        .front    (front),
        .ext_hold (ext_hold),
        .out_ready(out_ready),
        .sel      (sel),
        .go       (go),
        .fire     (fire),
        .lock_own (lock_own)
    );

    assign out_flit = front;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign out_valid[c] = go && (sel == chan_e'(c));

        AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (rst)
            lock_own[c] |-> !out_valid[NUM_CH-1-c]); // R3

        AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
            lock_own[c] && out_valid[c] && !out_ready[c]
            |=> out_valid[c] && $stable(out_flit)); // R5

        AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
            out_valid[c] && opens_pkt(front.kind) |-> !ext_hold[c]); // R6
    end

    AST_EJECT_ROUTE: assert property (@(posedge clk) disable iff (rst)
        out_valid[CH_EJECT] && opens_pkt(front.kind)
        |-> (dest_of(front) == DEST_W'(NODE_ID))); // R2

    AST_PASS_ROUTE: assert property (@(posedge clk) disable iff (rst)
        out_valid[CH_PASS] && opens_pkt(front.kind)
        |-> (dest_of(front) != DEST_W'(NODE_ID))); // R2

endmodule

// File: tb/wh_fwd_port_bench.sv
`timescale 1ns/1ps
module wh_fwd_port_bench;

    localparam int DEPTH     = 4;
    localparam int NODE_ID   = 5;
    localparam int NPKT      = 48;
    localparam int NSTIM_MAX = NPKT * 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [9:0] in_flit = '0;
    logic [1:0] ext_hold = '0;
    logic [1:0] out_valid;
    logic [1:0] out_ready = '0;
    logic [9:0] out_flit;
    logic [1:0] lock_own;

    always #2 clk = ~clk;

    wh_fwd_port #(
        .DEPTH(DEPTH),
        .NODE_ID(NODE_ID),
        .PKT_MAX_BITS(512)
    ) u_wh_fwd_port (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .ext_hold(ext_hold),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
        .lock_own(lock_own)
    );

    logic [9:0] stim  [NSTIM_MAX];
    logic       expch [NSTIM_MAX];
    int         nstim = 0;
    int         sidx  = 0;
    int         rptr  = 0;
    int         nvec  = 0;
    int         nfail = 0;
    int         cyc   = 0;
    logic [1:0] exp_lock = '0;
    logic       want_in = 1'b0;
    logic [1:0] rdy = '0;
    logic [1:0] hold = '0;
    bit         done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic build();
        for (int p = 0; p < NPKT; p++) begin
            int d;
            int len;
            d   = (5 * p + 5) % 16;
            len = 5 - (p % 5);
            for (int i = 0; i < len; i++) begin
                logic [1:0] k;
                logic [3:0] lo;
                if (len == 1)          k = 2'b11;
                else if (i == 0)       k = 2'b01;
                else if (i == len - 1) k = 2'b10;
                else                   k = 2'b00;
                // body data mimics the opposite destination to catch re-steering
                if (i == 0)            lo = 4'(d);
                else if (d == NODE_ID) lo = 4'hA;
                else                   lo = 4'(NODE_ID);
                stim[nstim]  = {k, 4'(p), lo};
                expch[nstim] = (d == NODE_ID) ? 1'b0 : 1'b1;
                nstim++;
            end
        end
    endtask

    task automatic step();
        logic [1:0] k;
        @(negedge clk);
        in_valid  = want_in && (sidx < nstim);
        in_flit   = (sidx < nstim) ? stim[sidx] : '0;
        out_ready = rdy;
        ext_hold  = hold;
        #1;
        chk(lock_own == exp_lock, "R3 R7 lock_own", 32'(lock_own), 32'(exp_lock));
        chk(!(out_valid[0] && out_valid[1]), "R3 both valid", 32'(out_valid), 32'd0);
        for (int c = 0; c < 2; c++) begin
            if (out_valid[c] && out_ready[c]) begin
                if (rptr >= nstim) begin
                    chk(1'b0, "R4 extra flit", 32'(out_flit), 32'd0);
                end else begin
                    chk(c == int'(expch[rptr]), "R2 R3 channel", 32'(c), 32'(expch[rptr]));
                    chk(out_flit == stim[rptr], "R2 R4 flit", 32'(out_flit), 32'(stim[rptr]));
                    k = stim[rptr][9:8];
                    if (k == 2'b01)      exp_lock[c] = 1'b1;
                    else if (k == 2'b10) exp_lock[c] = 1'b0;
                    rptr++;
                end
            end
        end
        if (in_valid && in_ready) sidx++;
        cyc++;
    endtask

    initial begin
        #400000;
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog act=%0d exp=%0d", rptr, nstim);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        build();
        repeat (3) begin
            @(negedge clk);
            #1;
            chk(out_valid == 2'b00, "R1 out_valid in reset", 32'(out_valid), 32'd0);
            chk(lock_own == 2'b00, "R1 lock_own in reset", 32'(lock_own), 32'd0);
            chk(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'd1);
        end
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 2'b00, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

        // cut-through and fill: packet 0 is local, five flits, outputs stalled
        want_in = 1'b1; rdy = 2'b00; hold = 2'b00;
        step();
        step();
        chk(out_valid == 2'b01, "R8 head offered next cycle", 32'(out_valid), 32'd1);
        chk(out_flit == stim[0], "R8 head flit", 32'(out_flit), 32'(stim[0]));
        repeat (DEPTH - 1) step();
        chk(in_ready == 1'b0, "R5 in_ready when full", 32'(in_ready), 32'd0);
        chk(out_valid == 2'b01 && out_flit == stim[0], "R5 stalled flit held",
            32'(out_flit), 32'(stim[0]));

        // hold: packet 1 targets pass while that channel is claimed
        hold = 2'b10; rdy = 2'b11;
        repeat (14) step();
        chk(rptr == 5, "R6 packet 0 delivered", 32'(rptr), 32'd5);
        chk(out_valid == 2'b00, "R6 held head not offered", 32'(out_valid), 32'd0);
        hold = 2'b00;
        step();
        chk(out_valid == 2'b10 && out_flit == stim[5], "R6 offered on release",
            32'(out_valid), 32'd2);

        // sweep over all destinations and lengths with mixed stalls and holds
        while (rptr < nstim && cyc < 20000) begin
            want_in = (cyc % 6) != 5;
            rdy[0]  = (cyc % 3) != 0;
            rdy[1]  = ((cyc / 2) % 4) != 3;
            hold[0] = !exp_lock[0] && ((cyc % 11) == 3);
            hold[1] = !exp_lock[1] && ((cyc % 11) == 7);
            step();
        end
        want_in = 1'b0; hold = 2'b00; rdy = 2'b11;
        step();
        chk(rptr == nstim, "R4 all flits delivered", 32'(rptr), 32'(nstim));
        chk(out_valid == 2'b00, "R4 nothing left", 32'(out_valid), 32'd0);
        chk(lock_own == 2'b00, "R3 lock released at end", 32'(lock_own), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule